// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Registers

This block keeps the interrupt register, the controller status register and the two configuration registers of a NAND-style flash controller, and derives the interrupt line, the ready line and a command-gating flag from them. A command engine outside the block reports completions and failures as single-cycle pulses. Software reaches the registers through a small select/write/read port and acknowledges an interrupt by writing zeros into the interrupt register.

The interrupt line's active level is chosen by a configuration bit: the line equals the pending flag XOR the inverse of that bit. Acknowledging the pending flag also wipes every error flag in the status register. While the pending flag is set, new command writes are dropped. Completion pulses and a software write in the same cycle are merged, with the pulses applied after the write mask. Two reset flavours exist: cold (the reset pin, or a cold request) and warm (a warm request). They differ only in the value loaded into the interrupt register.

Top module: `flash_irq_status`

## Requirements
- R1: A completion pulse sets its own interrupt bit together with the pending bit 15 on the next clock. The bit positions are load = bit 7, program = bit 6, erase = bit 5 and reset-done = bit 4. The generic done pulse sets only bit 15.
- R2: An error pulse sets its own status bit on the next clock: load = bit 13, program = bit 12, erase = bit 11. Each of these also sets the command-error bit 10. A command-error pulse sets only bit 10.
- R3: A write to the interrupt register replaces its contents with the bitwise AND of the old contents and the written word.
- R4: When an interrupt-register write leaves bit 15 at zero, status bits 13..10 are all cleared on that clock. When bit 15 survives the write, the status register keeps its value.
- R5: `irq_o` equals interrupt bit 15 XOR NOT configuration-1 bit 6. It follows a change in either register on the cycle after the write.
- R6: While interrupt bit 15 is set, a command write is dropped: `cmd_go_o` stays low and `cmd_code_o` keeps its value. Otherwise the word is latched into `cmd_code_o` and `cmd_go_o` is high for the one cycle that follows the write. `cmd_blocked_o` mirrors interrupt bit 15.
- R7: A cold reset (`rst_n` low or `cold_rst_req`) loads interrupt = 0x8080. A warm reset (`warm_rst_req`) loads interrupt = 0x8010. Both load configuration 1 = 0x40C0, configuration 2 = 0, status = 0, command = 0 and drive `ready_o` high. Cold wins when both reset requests arrive together.
- R8: A write to configuration 1 sets `ready_o` to bit 7 of the written word. A read of configuration 1 returns the stored word with bits 4..0 forced to zero.
- R9: When a completion or error pulse coincides with a software write to the interrupt register, the pulse's bits are ORed in after the AND mask and after any error wipe.
- R10: Writes to the status register have no effect. Configuration 2 reads back exactly the word written.
- R11: `reg_sel` codes are 0 = configuration 1, 1 = configuration 2, 2 = status, 3 = interrupt and 4 = command. `reg_rdata` shows the selected register in the same cycle, and any other code reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (cold) |
| reg_sel | input | 3 | Register select code |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| ev_load_done | input | 1 | Load-completion pulse |
| ev_prog_done | input | 1 | Program-completion pulse |
| ev_erase_done | input | 1 | Erase-completion pulse |
| ev_reset_done | input | 1 | Warm-reset-completion pulse |
| ev_cmd_done | input | 1 | Generic command-completion pulse |
| err_cmd | input | 1 | Command error pulse |
| err_erase | input | 1 | Erase error pulse |
| err_prog | input | 1 | Program error pulse |
| err_load | input | 1 | Load error pulse |
| cold_rst_req | input | 1 | Cold reset request |
| warm_rst_req | input | 1 | Warm reset request |
| irq_o | output | 1 | Interrupt line, polarity set by configuration 1 bit 6 |
| ready_o | output | 1 | Ready line |
| cmd_blocked_o | output | 1 | High while command writes are dropped |
| cmd_go_o | output | 1 | One-cycle strobe for an accepted command write |
| cmd_code_o | output | 16 | Last accepted command word |

## Verification
Every register updates on the clock edge that captures the write or pulse. The effect of a stimulus is therefore visible in the cycle directly after that edge. That covers the new register value, the interrupt and ready levels, the blocking flag and the one-cycle command strobe. Read data is a combinational view of the selected register, so a read needs no extra wait. The bench drives each stimulus just after a rising edge and holds it for exactly one edge. Each expected item is queued for the cycle that follows, and the monitor compares it on the falling edge of that cycle. The command-strobe check sits in the first cycle after the write, where the strobe must be high or low.

// File: rtl/flash_irq_pkg.sv
// Shared constants and types for the flash interrupt/status register block.
// Assumes a 16-bit register word; bit positions are fixed by the software
// view of the registers and are not meant to be changed.
package flash_irq_pkg;

    localparam int REG_W  = 16;
    localparam int SEL_W  = 3;
    localparam int N_DONE = 5;   // load, program, erase, reset-done, generic
    localparam int N_ERR  = 4;   // command, erase, program, load

    typedef logic [REG_W-1:0] word_t;

    // interrupt register layout
    localparam int PEND_BIT = 15;
    // order of the done-event vector: load, program, erase, reset-done, generic
    localparam int DONE_POS [N_DONE] = '{7, 6, 5, 4, 15};

    // status register layout; order: command, erase, program, load
    localparam int ERR_CMD_BIT = 10;
    localparam int ERR_POS [N_ERR] = '{10, 11, 12, 13};

    // configuration 1 fields
    localparam int CFG1_POL_BIT = 6;
    localparam int CFG1_RDY_BIT = 7;

    localparam word_t PEND_MASK    = word_t'(1) << PEND_BIT;
    localparam word_t ERR_ALL_MASK = word_t'(16'h3C00);
    localparam word_t INT_COLD     = word_t'(16'h8080);
    localparam word_t INT_WARM     = word_t'(16'h8010);
    localparam word_t CFG1_RST     = word_t'(16'h40C0);
    localparam word_t CFG1_RD_MASK = word_t'(16'hFFE0);

    typedef enum logic [SEL_W-1:0] {
        SEL_CFG1   = 3'd0,
        SEL_CFG2   = 3'd1,
        SEL_STATUS = 3'd2,
        SEL_INTR   = 3'd3,
        SEL_CMD    = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/fis_intr_reg.sv
// Interrupt register and interrupt line.
// Does: applies the software AND mask, then ORs in completion bits (each with
// the pending bit), and drives the interrupt line with selectable polarity.
// Assumes: cold request outranks warm request; rst_n is synchronous.
module fis_intr_reg
    import flash_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cold_req,
    input  logic              warm_req,
    input  logic              wr_en,
    input  word_t             wdata,
    input  logic [N_DONE-1:0] done_ev,
    input  logic              pol_bit,
    output word_t             intr_q,
    output logic              irq_o,
    output logic              err_wipe
);

    word_t ev_set [N_DONE];
    word_t set_all;
    word_t masked;

    // one set-mask per completion source
    for (genvar g = 0; g < N_DONE; g++) begin : g_done
        assign ev_set[g] = done_ev[g] ? ((word_t'(1) << DONE_POS[g]) | PEND_MASK) : '0;
    end

    // merge all completion set-masks
    always_comb begin
        set_all = '0;
        for (int i = 0; i < N_DONE; i++) begin
            set_all = set_all | ev_set[i];
        end
    end

    assign masked   = wr_en ? (intr_q & wdata) : intr_q;
    assign err_wipe = wr_en && !masked[PEND_BIT];

    // interrupt register: reset values, else mask then set
    always_ff @(posedge clk) begin
        if (!rst_n || cold_req) begin
            intr_q <= INT_COLD;
        end else if (warm_req) begin
            intr_q <= INT_WARM;
        end else begin
            intr_q <= masked | set_all;
        end
    end

    assign irq_o = intr_q[PEND_BIT] ^ ~pol_bit;

endmodule

// File: rtl/fis_status_reg.sv
// Controller status register (error flags only).
// Does: clears all error flags on an acknowledge that drops the pending bit,
// then sets each reported error together with the command-error flag.
// Assumes: software cannot write this register directly.
module fis_status_reg
    import flash_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_rst,
    input  logic             err_wipe,
    input  logic [N_ERR-1:0] err_ev,
    output word_t            status_q
);

    word_t err_set [N_ERR];
    word_t set_all;
    word_t kept;

    // one set-mask per error source
    for (genvar g = 0; g < N_ERR; g++) begin : g_err
        assign err_set[g] = err_ev[g] ?
            ((word_t'(1) << ERR_POS[g]) | (word_t'(1) << ERR_CMD_BIT)) : '0;
    end

    // merge all error set-masks
    always_comb begin
        set_all = '0;
        for (int i = 0; i < N_ERR; i++) begin
            set_all = set_all | err_set[i];
        end
    end

    assign kept = err_wipe ? (status_q & ~ERR_ALL_MASK) : status_q;

    // status register: reset to zero, else wipe then set
    always_ff @(posedge clk) begin
        if (!rst_n || any_rst) begin
            status_q <= '0;
        end else begin
            status_q <= kept | set_all;
        end
    end

endmodule

// File: rtl/fis_cfg_reg.sv
// Configuration registers 1 and 2 and the ready line.
// Does: stores both words; ready follows bit 7 of each configuration-1 write
// and is raised by any reset.
// Assumes: write strobes are already decoded per register.
module fis_cfg_reg
    import flash_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  any_rst,
    input  logic  wr_cfg1,
    input  logic  wr_cfg2,
    input  word_t wdata,
    output word_t cfg1_q,
    output word_t cfg2_q,
    output logic  ready_q
);

    // configuration words and ready line
    always_ff @(posedge clk) begin
        if (!rst_n || any_rst) begin
            cfg1_q  <= CFG1_RST;
            cfg2_q  <= '0;
            ready_q <= 1'b1;
        end else begin
            if (wr_cfg1) begin
                cfg1_q  <= wdata;
                ready_q <= wdata[CFG1_RDY_BIT];
            end
            if (wr_cfg2) begin
                cfg2_q <= wdata;
            end
        end
    end

endmodule

// File: rtl/fis_cmd_gate.sv
// Command register gate.
// Does: accepts a command word only while no interrupt is pending and emits a
// one-cycle go strobe for each accepted word.
// Assumes: the pending flag is the registered interrupt bit 15.
module fis_cmd_gate
    import flash_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  any_rst,
    input  logic  wr_cmd,
    input  logic  pending,
    input  word_t wdata,
    output word_t cmd_q,
    output logic  go_q
);

    logic accept;
    assign accept = wr_cmd && !pending;

    // command latch and go strobe
    always_ff @(posedge clk) begin
        if (!rst_n || any_rst) begin
            cmd_q <= '0;
            go_q  <= 1'b0;
        end else begin
            go_q <= accept;
            if (accept) begin
                cmd_q <= wdata;
            end
        end
    end

endmodule

// File: rtl/flash_irq_status.sv
// Top of the flash interrupt/status register block.
// Does: decodes register writes, routes event pulses to the interrupt and
// status registers, muxes read data and exposes the irq, ready and gating lines.
// Assumes: one register access per cycle; reads have no side effects.
module flash_irq_status
    import flash_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             ev_load_done,
    input  logic             ev_prog_done,
    input  logic             ev_erase_done,
    input  logic             ev_reset_done,
    input  logic             ev_cmd_done,
    input  logic             err_cmd,
    input  logic             err_erase,
    input  logic             err_prog,
    input  logic             err_load,
    input  logic             cold_rst_req,
    input  logic             warm_rst_req,
    output logic             irq_o,
    output logic             ready_o,
    output logic             cmd_blocked_o,
    output logic             cmd_go_o,
    output logic [REG_W-1:0] cmd_code_o
);

    word_t intr_q, status_q, cfg1_q, cfg2_q, cmd_q;
    logic  err_wipe, any_rst;
    logic  wr_cfg1, wr_cfg2, wr_intr, wr_cmd;
    logic [N_DONE-1:0] done_ev;
    logic [N_ERR-1:0]  err_ev;

    assign any_rst = cold_rst_req || warm_rst_req;
    assign wr_cfg1 = reg_wr && (reg_sel == SEL_CFG1);
    assign wr_cfg2 = reg_wr && (reg_sel == SEL_CFG2);
    assign wr_intr = reg_wr && (reg_sel == SEL_INTR);
    assign wr_cmd  = reg_wr && (reg_sel == SEL_CMD);

    assign done_ev = {ev_cmd_done, ev_reset_done, ev_erase_done, ev_prog_done, ev_load_done};
    assign err_ev  = {err_load, err_prog, err_erase, err_cmd};

    fis_intr_reg u_intr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cold_req (cold_rst_req),
        .warm_req (warm_rst_req),
        .wr_en    (wr_intr),
        .wdata    (reg_wdata),
        .done_ev  (done_ev),
        .pol_bit  (cfg1_q[CFG1_POL_BIT]),
        .intr_q   (intr_q),
        .irq_o    (irq_o),
        .err_wipe (err_wipe)
    );

    fis_status_reg u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_rst  (any_rst),
        .err_wipe (err_wipe),
        .err_ev   (err_ev),
        .status_q (status_q)
    );

    fis_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_rst (any_rst),
        .wr_cfg1 (wr_cfg1),
        .wr_cfg2 (wr_cfg2),
        .wdata   (reg_wdata),
        .cfg1_q  (cfg1_q),
        .cfg2_q  (cfg2_q),
        .ready_q (ready_o)
    );

    fis_cmd_gate u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_rst (any_rst),
        .wr_cmd  (wr_cmd),
        .pending (intr_q[PEND_BIT]),
        .wdata   (reg_wdata),
        .cmd_q   (cmd_q),
        .go_q    (cmd_go_o)
    );

    // read-data multiplexer
    always_comb begin
        case (reg_sel)
            SEL_CFG1:   reg_rdata = cfg1_q & CFG1_RD_MASK;
            SEL_CFG2:   reg_rdata = cfg2_q;
            SEL_STATUS: reg_rdata = status_q;
            SEL_INTR:   reg_rdata = intr_q;
            SEL_CMD:    reg_rdata = cmd_q;
            default:    reg_rdata = '0;
        endcase
    end

    assign cmd_blocked_o = intr_q[PEND_BIT];
    assign cmd_code_o    = cmd_q;

endmodule

// File: rtl/fis_chk.sv
// Assertion checker for flash_irq_status, attached with bind below.
// Does: checks register update rules across clock edges.
// Assumes: all inputs are the top's ports and internal register words.
module fis_chk
    import flash_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] reg_sel,
    input logic             reg_wr,
    input word_t            reg_wdata,
    input logic [N_DONE-1:0] done_ev,
    input logic [N_ERR-1:0]  err_ev,
    input logic             cold_rst_req,
    input logic             warm_rst_req,
    input word_t            intr_q,
    input word_t            status_q,
    input logic             irq_o,
    input logic             ready_o,
    input logic             cmd_go_o
);

    logic quiet;
    assign quiet = !cold_rst_req && !warm_rst_req && (done_ev == '0) && (err_ev == '0);

    p_and_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_INTR && quiet) |=> intr_q == ($past(intr_q) & $past(reg_wdata)));

    p_err_wipe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_INTR && quiet && !(intr_q[PEND_BIT] && reg_wdata[PEND_BIT]))
        |=> (status_q & ERR_ALL_MASK) == '0);

    p_prog_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ev[2] && !cold_rst_req && !warm_rst_req) |=> status_q[12] && status_q[ERR_CMD_BIT]);

    p_polarity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_CFG1 && quiet)
        |=> irq_o == ($past(intr_q[PEND_BIT]) ^ ~$past(reg_wdata[CFG1_POL_BIT])));

    p_cmd_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_CMD && intr_q[PEND_BIT]) |=> !cmd_go_o);

    p_cold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cold_rst_req |=> intr_q == INT_COLD && status_q == '0 && ready_o);

    p_warm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_rst_req && !cold_rst_req) |=> intr_q == INT_WARM && status_q == '0);

    p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_CFG1 && !cold_rst_req && !warm_rst_req)
        |=> ready_o == $past(reg_wdata[CFG1_RDY_BIT]));

    p_load_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ev[0] && !cold_rst_req && !warm_rst_req) |=> intr_q[7] && intr_q[PEND_BIT]);

endmodule

bind flash_irq_status fis_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_sel      (reg_sel),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .done_ev      (done_ev),
    .err_ev       (err_ev),
    .cold_rst_req (cold_rst_req),
    .warm_rst_req (warm_rst_req),
    .intr_q       (intr_q),
    .status_q     (status_q),
    .irq_o        (irq_o),
    .ready_o      (ready_o),
    .cmd_go_o     (cmd_go_o)
);

// File: tb/flash_irq_status_tb.sv
module flash_irq_status_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  reg_sel;
    logic        reg_wr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic ev_load_done, ev_prog_done, ev_erase_done, ev_reset_done, ev_cmd_done;
    logic err_cmd, err_erase, err_prog, err_load;
    logic cold_rst_req, warm_rst_req;
    logic irq_o, ready_o, cmd_blocked_o, cmd_go_o;
    logic [15:0] cmd_code_o;

    always #5 clk = ~clk;

    flash_irq_status u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_load_done(ev_load_done), .ev_prog_done(ev_prog_done),
        .ev_erase_done(ev_erase_done), .ev_reset_done(ev_reset_done),
        .ev_cmd_done(ev_cmd_done), .err_cmd(err_cmd), .err_erase(err_erase),
        .err_prog(err_prog), .err_load(err_load),
        .cold_rst_req(cold_rst_req), .warm_rst_req(warm_rst_req),
        .irq_o(irq_o), .ready_o(ready_o), .cmd_blocked_o(cmd_blocked_o),
        .cmd_go_o(cmd_go_o), .cmd_code_o(cmd_code_o)
    );

    localparam int K_RD = 0, K_IRQ = 1, K_RDY = 2, K_BLK = 3, K_GO = 4;
    localparam logic [2:0] S_CFG1 = 3'd0, S_CFG2 = 3'd1, S_STAT = 3'd2,
                           S_INTR = 3'd3, S_CMD = 3'd4;

    typedef struct {
        int          kind;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    logic  take = 1'b0;
    logic  done = 1'b0;
    int    total = 0;
    int    bad = 0;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    // driver: queue one expected item and present it to the monitor for a cycle
    task automatic expect_v(input int kind, input logic [2:0] sel,
                            input logic [15:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        reg_sel = sel;
        exp_q.push_back(it);
        take = 1'b1;
        tick();
        take = 1'b0;
    endtask

    // monitor: pop and compare on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (take && exp_q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = exp_q.pop_front();
                case (it.kind)
                    K_RD:    act = reg_rdata;
                    K_IRQ:   act = {15'd0, irq_o};
                    K_RDY:   act = {15'd0, ready_o};
                    K_BLK:   act = {15'd0, cmd_blocked_o};
                    default: act = {15'd0, cmd_go_o};
                endcase
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    // watchdog
    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_sel = '0; reg_wr = 1'b0; reg_wdata = '0;
        {ev_load_done, ev_prog_done, ev_erase_done, ev_reset_done, ev_cmd_done} = '0;
        {err_cmd, err_erase, err_prog, err_load} = '0;
        cold_rst_req = 1'b0; warm_rst_req = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;

        // reset state
        expect_v(K_RD,  S_INTR, 16'h8080, "R7 cold intr");
        expect_v(K_RD,  S_CFG1, 16'h40C0, "R7 cold cfg1");
        expect_v(K_RD,  S_CFG2, 16'h0000, "R7 cold cfg2");
        expect_v(K_RD,  S_STAT, 16'h0000, "R7 cold status");
        expect_v(K_IRQ, S_INTR, 16'h0001, "R5 irq after reset");
        expect_v(K_RDY, S_INTR, 16'h0001, "R7 ready after reset");
        expect_v(K_BLK, S_INTR, 16'h0001, "R6 blocked after reset");

        // command while pending is dropped
        wr(S_CMD, 16'h0094);
        expect_v(K_GO, S_CMD, 16'h0000, "R6 no go while pending");
        expect_v(K_RD, S_CMD, 16'h0000, "R6 code kept while pending");

        // acknowledge
        wr(S_INTR, 16'h7FFF);
        expect_v(K_RD,  S_INTR, 16'h0080, "R3 and-write");
        expect_v(K_IRQ, S_INTR, 16'h0000, "R5 irq low after ack");
        expect_v(K_BLK, S_INTR, 16'h0000, "R6 unblocked");

        // accepted command
        wr(S_CMD, 16'h0080);
        expect_v(K_GO, S_CMD, 16'h0001, "R6 go strobe");
        expect_v(K_GO, S_CMD, 16'h0000, "R6 go one cycle");
        expect_v(K_RD, S_CMD, 16'h0080, "R6 code latched");

        // program done
        ev_prog_done = 1'b1; tick(); ev_prog_done = 1'b0;
        expect_v(K_RD,  S_INTR, 16'h80C0, "R1 program done");
        expect_v(K_IRQ, S_INTR, 16'h0001, "R5 irq high on pending");

        // errors
        err_prog = 1'b1; tick(); err_prog = 1'b0;
        expect_v(K_RD, S_STAT, 16'h1400, "R2 program error");
        err_cmd = 1'b1; tick(); err_cmd = 1'b0;
        expect_v(K_RD, S_STAT, 16'h1400, "R2 command error");
        err_load = 1'b1; tick(); err_load = 1'b0;
        expect_v(K_RD, S_STAT, 16'h3400, "R2 load error");
        err_erase = 1'b1; tick(); err_erase = 1'b0;
        expect_v(K_RD, S_STAT, 16'h3C00, "R2 erase error");

        // status is read-only
        wr(S_STAT, 16'h0000);
        expect_v(K_RD, S_STAT, 16'h3C00, "R10 status write ignored");

        // ack keeping bit 15 leaves errors
        wr(S_INTR, 16'hFFFF);
        expect_v(K_RD, S_INTR, 16'h80C0, "R3 and with ones");
        expect_v(K_RD, S_STAT, 16'h3C00, "R4 errors kept");

        // ack dropping bit 15 wipes errors
        wr(S_INTR, 16'h7F3F);
        expect_v(K_RD, S_INTR, 16'h0000, "R3 and clears");
        expect_v(K_RD, S_STAT, 16'h0000, "R4 errors wiped");

        // same-cycle write and events
        reg_sel = S_INTR; reg_wdata = 16'h0000; reg_wr = 1'b1;
        ev_load_done = 1'b1; err_load = 1'b1;
        tick();
        reg_wr = 1'b0; ev_load_done = 1'b0; err_load = 1'b0;
        expect_v(K_RD, S_INTR, 16'h8080, "R9 event after mask");
        expect_v(K_RD, S_STAT, 16'h2400, "R9 error after wipe");

        // polarity and ready
        wr(S_CFG1, 16'h0080);
        expect_v(K_IRQ, S_INTR, 16'h0000, "R5 inverted polarity");
        expect_v(K_RD,  S_CFG1, 16'h0080, "R8 cfg1 read");
        wr(S_CFG1, 16'h005F);
        expect_v(K_RDY, S_INTR, 16'h0000, "R8 ready from bit 7");
        expect_v(K_RD,  S_CFG1, 16'h0040, "R8 low bits masked");
        expect_v(K_IRQ, S_INTR, 16'h0001, "R5 normal polarity");

        wr(S_CFG2, 16'hBEEF);
        expect_v(K_RD, S_CFG2, 16'hBEEF, "R10 cfg2 readback");

        // warm reset
        warm_rst_req = 1'b1; tick(); warm_rst_req = 1'b0;
        expect_v(K_RD,  S_INTR, 16'h8010, "R7 warm intr");
        expect_v(K_RD,  S_CFG1, 16'h40C0, "R7 warm cfg1");
        expect_v(K_RD,  S_CFG2, 16'h0000, "R7 warm cfg2");
        expect_v(K_RD,  S_STAT, 16'h0000, "R7 warm status");
        expect_v(K_RDY, S_INTR, 16'h0001, "R7 warm ready");

        // remaining completion kinds
        wr(S_INTR, 16'h0000);
        ev_cmd_done = 1'b1; tick(); ev_cmd_done = 1'b0;
        expect_v(K_RD, S_INTR, 16'h8000, "R1 generic done");
        wr(S_INTR, 16'h0000);
        ev_reset_done = 1'b1; tick(); ev_reset_done = 1'b0;
        expect_v(K_RD, S_INTR, 16'h8010, "R1 reset done");
        wr(S_INTR, 16'h0000);
        ev_erase_done = 1'b1; tick(); ev_erase_done = 1'b0;
        expect_v(K_RD, S_INTR, 16'h8020, "R1 erase done");

        // cold beats warm
        cold_rst_req = 1'b1; warm_rst_req = 1'b1; tick();
        cold_rst_req = 1'b0; warm_rst_req = 1'b0;
        expect_v(K_RD, S_INTR, 16'h8080, "R7 cold priority");

        // unknown selector
        expect_v(K_RD, 3'd7, 16'h0000, "R11 unknown selector");

        tick();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule